// File: doc/BRIEF.md
# Rotate-and-Mask Field Merger

This block merges a bit field taken from one operand into a second operand. The M operand can be rotated left by a shared count. A mask of contiguous ones is built from a length code, and that mask can also be rotated left by the same count. Where the mask is set, the result takes the bit from the (possibly rotated) M operand. Everywhere else the result keeps the bit from the A operand.

Two separate enables decide which of the two paths the count is applied to. This lets one datapath serve several roles:
- Rotate the data only: a field is extracted down to the low bits.
- Rotate both data and mask: a low field is deposited at a chosen position.
- Rotate the mask only: a field is copied to the same position in the other word.

A force input sets the most significant bit of the count. This lets a one-bit flag from outside pick between two halves of the rotate range.

The result is normally registered. A valid flag follows each request by one cycle. A parameter selects a purely combinational variant instead.

Top module: `field_merge_unit`

## Requirements
- R1: The length input `fld_len` encodes the field width minus one. Value 0 selects a 1-bit field and the all-ones value selects a field as wide as the word. Before any rotation the mask is `fld_len+1` ones starting at bit 0.
- R2: When `rot_data_en` is 1, the M operand is rotated left by the effective count, with bit i moving to bit (i+count) mod DATA_W. When it is 0, M is used unrotated.
- R3: When `rot_mask_en` is 1, the mask is rotated left by the effective count. When it is 0, the mask starts at bit 0.
- R4: Result bits at mask positions come from the prepared M operand. All other result bits equal `opnd_a`.
- R5: The effective count is `rot_cnt` with its most significant bit forced to 1 when both `force_hi_en` and `pc_lsb` are 1. If either of them is 0, the count is used unchanged.
- R6: With a full-width length and the mask rotated, the mask wraps around with no gap, so the result equals the prepared M operand in every bit.
- R7: In the registered variant (default), `out_word` shows the result of a request one clock edge after `req_valid` is sampled high. `out_valid` is high exactly in the cycle after each request.
- R8: In the registered variant, a cycle with `req_valid` low leaves `out_word` unchanged and drives `out_valid` low.
- R9: After reset, `out_valid` and `out_word` are 0.
- R10: In the combinational variant, `out_word` is the merged result of the current inputs in the same cycle, and `out_valid` equals `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; inputs below are valid |
| opnd_a | input | DATA_W | Base word whose unmasked bits pass through |
| opnd_m | input | DATA_W | Source word supplying the field |
| rot_cnt | input | log2(DATA_W) | Left-rotate count |
| fld_len | input | log2(DATA_W) | Field width minus one |
| rot_data_en | input | 1 | Apply count to the M operand |
| rot_mask_en | input | 1 | Apply count to the mask |
| force_hi_en | input | 1 | Allow forcing the count's top bit |
| pc_lsb | input | 1 | External flag; forces the count's top bit when allowed |
| out_valid | output | 1 | Result valid |
| out_word | output | DATA_W | Merged word |

## Verification
The bench builds two copies of the block.

The first uses the defaults: 32 bits and a registered output. It exercises:
- the full five-stage rotator;
- the registered timing and the hold of the output register between requests;
- force on the 16-position rotate bit.

The second copy is 8 bits wide and combinational. Random counts and lengths there cover every rotate value and every field width many times over, including the wrap-around cases. The same stimulus also checks that the output follows the inputs in the same cycle.

// File: rtl/fmu_pkg.sv
package fmu_pkg;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_style_e;

endpackage

// File: rtl/fmu_rotl.sv
module fmu_rotl #(
   parameter int W  = 32,
   parameter int CW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [CW-1:0] cnt,
   output logic [W-1:0]  dout
);

   logic [W-1:0] stg [0:CW];

   assign stg[0] = din;

   for (genvar s = 0; s < CW; s++) begin : g_stage
      localparam int SH = 1 << s;
      logic [W-1:0] rotated;
      assign rotated    = {stg[s][W-1-SH:0], stg[s][W-1:W-SH]};
      assign stg[s + 1] = cnt[s] ? rotated : stg[s];
   end

   assign dout = stg[CW];

endmodule

// File: rtl/fmu_mask_gen.sv
module fmu_mask_gen #(
   parameter int W  = 32,
   parameter int CW = $clog2(W)
) (
   input  logic [CW-1:0] len_m1,
   output logic [W-1:0]  mask
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      localparam logic [CW-1:0] IDX = CW'(i);
      assign mask[i] = (IDX <= len_m1);
   end

endmodule

// File: rtl/field_merge_unit.sv
module field_merge_unit #(
   parameter int                 DATA_W    = 32,
   parameter fmu_pkg::out_style_e OUT_STYLE = fmu_pkg::OUT_REG,
   localparam int                CNT_W     = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_m,
   input  logic [CNT_W-1:0]  rot_cnt,
   input  logic [CNT_W-1:0]  fld_len,
   input  logic              rot_data_en,
   input  logic              rot_mask_en,
   input  logic              force_hi_en,
   input  logic              pc_lsb,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_word
);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("field_merge_unit: DATA_W must be a power of two, at least 2");
   end

   localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(1) << (CNT_W - 1);

   logic [CNT_W-1:0]  eff_cnt;
   logic [CNT_W-1:0]  data_cnt;
   logic [CNT_W-1:0]  mask_cnt;
   logic [DATA_W-1:0] m_prep;
   logic [DATA_W-1:0] mask_base;
   logic [DATA_W-1:0] mask_fin;
   logic [DATA_W-1:0] merged;

   assign eff_cnt  = (force_hi_en && pc_lsb) ? (rot_cnt | TOP_BIT) : rot_cnt;
   assign data_cnt = rot_data_en ? eff_cnt : '0;
   assign mask_cnt = rot_mask_en ? eff_cnt : '0;

   fmu_rotl #(.W(DATA_W), .CW(CNT_W)) i_data_rot (
      .din  (opnd_m),
      .cnt  (data_cnt),
      .dout (m_prep)
   );

   fmu_mask_gen #(.W(DATA_W), .CW(CNT_W)) i_mask_gen (
      .len_m1 (fld_len),
      .mask   (mask_base)
   );

   fmu_rotl #(.W(DATA_W), .CW(CNT_W)) i_mask_rot (
      .din  (mask_base),
      .cnt  (mask_cnt),
      .dout (mask_fin)
   );

   assign merged = (opnd_a & ~mask_fin) | (m_prep & mask_fin);

   if (OUT_STYLE == fmu_pkg::OUT_REG) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
         end else begin
            out_valid <= req_valid;
            if (req_valid) out_word <= merged;
         end
      end

      // R7
      valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> out_valid);
      // R8
      idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !out_valid);
      // R8
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> $stable(out_word));
   end else begin : g_comb_out
      assign out_valid = req_valid;
      assign out_word  = merged;
   end

   // R1
   mask_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(mask_fin) == int'(fld_len) + 1);
   // R2
   data_rot_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(m_prep) == $countones(opnd_m));
   // R3
   mask_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rot_mask_en |-> mask_fin[0]);
   // R5
   force_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_hi_en && pc_lsb && rot_mask_en && fld_len == '0) |->
      $countones(mask_fin[DATA_W-1:DATA_W/2]) == 1);

endmodule

// File: tb/test_field_merge_unit.sv
module test_field_merge_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] a = '0, m = '0;
   logic [4:0]  cnt = '0, len = '0;
   logic        zr = 1'b0, zm = 1'b0, frc = 1'b0, pc = 1'b0;
   logic        v32, v8;
   logic [31:0] o32;
   logic [7:0]  o8;
   int          checks = 0, fails = 0;
   int          cyc = 0;
   logic [31:0] last32;

   always #2.5 clk = ~clk;

   field_merge_unit i_field_merge_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .opnd_a(a), .opnd_m(m), .rot_cnt(cnt), .fld_len(len),
      .rot_data_en(zr), .rot_mask_en(zm), .force_hi_en(frc), .pc_lsb(pc),
      .out_valid(v32), .out_word(o32));

   field_merge_unit #(.DATA_W(8), .OUT_STYLE(fmu_pkg::OUT_COMB)) i_field_merge_unit_n8 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .opnd_a(a[7:0]), .opnd_m(m[7:0]), .rot_cnt(cnt[2:0]), .fld_len(len[2:0]),
      .rot_data_en(zr), .rot_mask_en(zm), .force_hi_en(frc), .pc_lsb(pc),
      .out_valid(v8), .out_word(o8));

   function automatic logic [31:0] rotl(input logic [31:0] x, input int n, input int w);
      logic [31:0] wm = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      logic [31:0] r = x & wm;
      for (int k = 0; k < n; k++) r = ((r << 1) | (r >> (w - 1))) & wm;
      return r;
   endfunction

   function automatic logic [31:0] model(input logic [31:0] aa, mm, input int c, l,
                                         input logic dz, mz, f, p, input int w);
      logic [31:0] wm = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
      logic [31:0] msk = '0;
      logic [31:0] dr, mr;
      int ce = c;
      if (f && p) ce = ce | (w / 2);
      for (int k = 0; k <= l; k++) msk[k] = 1'b1;
      dr = dz ? rotl(mm, ce, w) : (mm & wm);
      mr = mz ? rotl(msk, ce, w) : msk;
      return ((aa & ~mr) | (dr & mr)) & wm;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one request: checks narrow comb copy in-cycle, wide copy after the edge
   task automatic run_vec(input string req, input logic [31:0] ia, im,
                          input int ic, il, input logic dz, mz, f, p);
      logic [31:0] e32, e8;
      @(negedge clk);
      req_valid = 1'b1; a = ia; m = im; cnt = 5'(ic); len = 5'(il);
      zr = dz; zm = mz; frc = f; pc = p;
      e32 = model(ia, im, ic, il, dz, mz, f, p, 32);
      e8  = model(ia, im, ic & 7, il & 7, dz, mz, f, p, 8);
      #1;
      chk({req, " R10 n8 word"}, {24'd0, o8}, e8);
      chk({req, " R10 n8 valid"}, {31'd0, v8}, 32'd1);
      @(negedge clk);
      chk({req, " R7 word"}, o32, e32);
      chk({req, " R7 valid"}, {31'd0, v32}, 32'd1);
      last32 = e32;
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
         end
      end
   end

   initial begin : stim
      process::self().srandom(32'd1975);
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 word", o32, 32'd0);
      chk("R9 valid", {31'd0, v32}, 32'd0);
      rst_n = 1'b1;

      // R1 one-bit field at bit 0
      run_vec("R1 len0", 32'hFFFF_FFFF, 32'h0000_0000, 0, 0, 0, 0, 0, 0);
      // R2 extraction: data rotated, mask low
      run_vec("R2 extract", 32'h0, 32'h00AB_0000, 16, 7, 1, 0, 0, 0);
      // R3 deposit-to-same-position: mask rotated only
      run_vec("R3 samepos", 32'h1234_5678, 32'hFFFF_FFFF, 8, 3, 0, 1, 0, 0);
      // R4 full deposit
      run_vec("R4 deposit", 32'hDEAD_BEEF, 32'h0000_0005, 28, 3, 1, 1, 0, 0);
      // R5 force sets top count bit; no effect without flag
      run_vec("R5 forced", 32'h0, 32'h0000_0001, 3, 0, 1, 1, 1, 1);
      run_vec("R5 unforced", 32'h0, 32'h0000_0001, 3, 0, 1, 1, 1, 0);
      run_vec("R5 flag only", 32'h0, 32'h0000_0001, 3, 0, 1, 1, 0, 1);
      // R6 full width wraps
      run_vec("R6 wrap", 32'h5555_5555, 32'h8000_0001, 5, 31, 1, 1, 0, 0);
      run_vec("R6 wrap nodata", 32'h5555_5555, 32'hCAFE_F00D, 31, 31, 0, 1, 0, 0);

      // R8 idle cycle holds word, drops valid
      @(negedge clk);
      req_valid = 1'b0; a = 32'h0; m = 32'hFFFF_FFFF; len = 5'd31; zr = 1'b0; zm = 1'b0;
      #1;
      chk("R10 n8 valid idle", {31'd0, v8}, 32'd0);
      @(negedge clk);
      chk("R8 hold word", o32, last32);
      chk("R8 valid low", {31'd0, v32}, 32'd0);

      for (int n = 0; n < 400; n++) begin
         run_vec("R4 random", $urandom, $urandom, int'($urandom % 32), int'($urandom % 32),
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule